// File: doc/BRIEF.md
# Edge/Level Interrupt Controller Bank

This block gathers thirty-two interrupt lines into one bank and raises two request outputs, one for the normal interrupt class and one for the fast interrupt class. Each line has its own configuration word. The word picks whether the line reacts to a rising edge or to a high level, which class it belongs to, and its priority. Pending bits are held in a register that software can read and clear. A mask register blocks lines from taking part in arbitration.

Each class has a small state machine with two states. In `ST_ARMED` the class watches for unmasked pending lines that belong to it. When one is present, the machine takes the `capture` transition to `ST_FIRED`. On that transition it latches the winning line number into the class code register and raises its request output. In `ST_FIRED` the code is frozen and the request stays high. The `rearm` transition back to `ST_ARMED` happens only when software writes the class bit of the control register. That write drops the request, and the class is evaluated again in the next cycle. Reading a class code register returns the latched line number. If that line is edge-type, the read also clears its pending bit. A software trigger register lets software raise a pending bit on one line.

The external lines pass through two flops before edge detection. All outputs, read data included, are registered. The bus is a simple single-cycle strobe interface with 32-bit data. Read data appears one cycle after the read strobe. A write takes precedence when both strobes are high.

Top module: `intc_bank`

## Requirements
- R1: After reset the mask register (0x04) reads 0xFFFFFFFF, the pending register (0x00) and every configuration word read 0, both request outputs are low, and both classes are in `ST_ARMED`.
- R2: The configuration word of line n sits at 0x1C+4n. Bits [6:2] hold the priority, bit 1 selects level (1) or edge (0), and bit 0 steers the line to the fast class (1) or the normal class (0). Other bits read as 0.
- R3: An edge-type line sets its pending bit when its synchronized input rises, and the bit stays set after the input falls.
- R4: A level-type line sets its pending bit while its synchronized input is high. The bit clears when that input falls.
- R5: A write to the pending register clears every bit written as 0, except a level-type bit whose synchronized input is still high.
- R6: Among the pending lines of a class whose mask bit is 0 (mask bit 1 blocks), the line with the numerically lowest priority wins. Ties go to the highest line number. A request output goes high exactly when its class captures a winner.
- R7: Reading 0x10 (normal class) or 0x14 (fast class) returns the latched winner line number. If that line is edge-type, the read also clears its pending bit.
- R8: While a class is in `ST_FIRED`, its output stays high and its code stays frozen. A write to 0x18 with bit 0 (normal) or bit 1 (fast) set drops that output in the next cycle, and the class is evaluated again in the cycle after.
- R9: A write to the trigger register 0x9C acts only on the lowest set bit of the data. It sets that pending bit if the line is level-type or its synchronized input is low.
- R10: When a set event and a clear event hit the same pending bit in the same cycle, the bit ends up set.
- R11: The control register and the trigger register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lines_i | input | 32 | Asynchronous interrupt lines |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Normal-class request |
| fiq_o | output | 1 | Fast-class request |

## Verification
Two things can collide on the same cycle: a rising input that sets a pending bit, and a software write to the pending register that clears that same bit. The bench counts the flops from the pin through the synchronizer and the edge-detect register. It then issues the clearing write so that it lands on the very edge where the rise is detected. A readback of the pending register must show the bit still set.

The randomised rounds also mix software triggers that carry several set bits, which checks that only the lowest one is taken. They also check that code reads clear the winner while other lines of the same class stay pending.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_FIRED = 1'b1
    } arm_state_e;

    localparam int unsigned CLASS_CNT = 2;
    localparam int unsigned CLS_NORM  = 0;
    localparam int unsigned CLS_FAST  = 1;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
    parameter int unsigned LINES  = 32,
    parameter int unsigned PRIO_W = 5,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0]        active_i,
    input  logic [LINES*PRIO_W-1:0] prio_i,
    output logic                    found_o,
    output logic [IDX_W-1:0]        winner_o
);

    // Lower value wins; a later line with an equal value replaces the
    // current choice, so ties go to the higher line number.
    always_comb begin
        logic [PRIO_W-1:0] best;
        best     = '1;
        winner_o = '0;
        found_o  = 1'b0;
        for (int i = 0; i < int'(LINES); i++) begin
            if (active_i[i] && (prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
                best     = prio_i[i*PRIO_W +: PRIO_W];
                winner_o = IDX_W'(i);
                found_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/intc_arm_fsm.sv
module intc_arm_fsm
    import intc_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             found_i,
    input  logic [IDX_W-1:0] winner_i,
    input  logic             rearm_i,
    output logic             req_o,
    output logic [IDX_W-1:0] code_o
);

    arm_state_e       state_q;
    arm_state_e       state_d;
    logic             req_q;
    logic [IDX_W-1:0] code_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_ARMED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (found_i) state_d = ST_FIRED;  // capture
            ST_FIRED: if (rearm_i) state_d = ST_ARMED;  // rearm
            default:  state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q  <= 1'b0;
            code_q <= '0;
        end else begin
            req_q <= (state_d == ST_FIRED);
            if (state_q == ST_ARMED && state_d == ST_FIRED)
                code_q <= winner_i;
        end
    end

    assign req_o  = req_q;
    assign code_o = code_q;

    a_r8_fired_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FIRED && !rearm_i) |=> (req_o && $stable(code_o)));

    a_r8_rearm_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FIRED && rearm_i) |=> !req_o);

    a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ARMED && !found_i) |=> !req_o);

endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int unsigned LINES  = 32,
    parameter int unsigned PRIO_W = 5,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LINES-1:0]  lines_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int unsigned IDX_W     = $clog2(LINES);
    localparam int unsigned CFG_W     = PRIO_W + 2;
    localparam int unsigned A_PEND    = 'h00;
    localparam int unsigned A_MASK    = 'h04;
    localparam int unsigned A_CODE_N  = 'h10;
    localparam int unsigned A_CODE_F  = 'h14;
    localparam int unsigned A_CTRL    = 'h18;
    localparam int unsigned A_CFG0    = 'h1C;
    localparam int unsigned A_CFG_END = A_CFG0 + 4 * (LINES - 1);
    localparam int unsigned A_TRIG    = A_CFG_END + 4;

    // ---------------- input synchronisation and edge detect ----------------
    logic [LINES-1:0] sync_w;
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] rise_w;
    logic [LINES-1:0] fall_w;

    intc_sync #(.WIDTH(LINES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (lines_i),
        .sync_o  (sync_w)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= sync_w;
    end

    assign rise_w = sync_w & ~prev_q;
    assign fall_w = ~sync_w & prev_q;

    // ---------------- bus decode ----------------
    logic              wr_pend, wr_mask, wr_ctrl, wr_cfg, wr_trig;
    logic              rd_go, rd_code_n, rd_code_f;
    logic              cfg_hit;
    logic [ADDR_W-1:0] cfg_off;
    logic [IDX_W-1:0]  cfg_idx;

    assign cfg_off = bus_addr_i - ADDR_W'(A_CFG0);
    assign cfg_idx = cfg_off[IDX_W+1:2];
    assign cfg_hit = (bus_addr_i >= ADDR_W'(A_CFG0)) && (bus_addr_i <= ADDR_W'(A_CFG_END))
                     && (bus_addr_i[1:0] == 2'b00);

    assign wr_pend   = bus_wr_i && (bus_addr_i == ADDR_W'(A_PEND));
    assign wr_mask   = bus_wr_i && (bus_addr_i == ADDR_W'(A_MASK));
    assign wr_ctrl   = bus_wr_i && (bus_addr_i == ADDR_W'(A_CTRL));
    assign wr_trig   = bus_wr_i && (bus_addr_i == ADDR_W'(A_TRIG));
    assign wr_cfg    = bus_wr_i && cfg_hit;
    assign rd_go     = bus_rd_i && !bus_wr_i;
    assign rd_code_n = rd_go && (bus_addr_i == ADDR_W'(A_CODE_N));
    assign rd_code_f = rd_go && (bus_addr_i == ADDR_W'(A_CODE_F));

    // ---------------- configuration and mask storage ----------------
    logic [LINES*PRIO_W-1:0] prio_q;
    logic [LINES-1:0]        lvl_q;
    logic [LINES-1:0]        steer_q;
    logic [LINES-1:0]        mask_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prio_q  <= '0;
            lvl_q   <= '0;
            steer_q <= '0;
            mask_q  <= '1;
        end else begin
            if (wr_mask) mask_q <= bus_wdata_i[LINES-1:0];
            if (wr_cfg) begin
                prio_q[cfg_idx*PRIO_W +: PRIO_W] <= bus_wdata_i[PRIO_W+1:2];
                lvl_q[cfg_idx]                   <= bus_wdata_i[1];
                steer_q[cfg_idx]                 <= bus_wdata_i[0];
            end
        end
    end

    // ---------------- class arbitration and state machines ----------------
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] act_w;
    logic [LINES-1:0] cls_act [CLASS_CNT];
    logic             cls_found [CLASS_CNT];
    logic [IDX_W-1:0] cls_win [CLASS_CNT];
    logic             cls_req [CLASS_CNT];
    logic [IDX_W-1:0] cls_code [CLASS_CNT];

    assign act_w              = pend_q & ~mask_q;
    assign cls_act[CLS_NORM]  = act_w & ~steer_q;
    assign cls_act[CLS_FAST]  = act_w & steer_q;

    for (genvar c = 0; c < int'(CLASS_CNT); c++) begin : g_cls
        intc_prio_arb #(.LINES(LINES), .PRIO_W(PRIO_W)) u_arb (
            .active_i (cls_act[c]),
            .prio_i   (prio_q),
            .found_o  (cls_found[c]),
            .winner_o (cls_win[c])
        );

        intc_arm_fsm #(.IDX_W(IDX_W)) u_fsm (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .found_i  (cls_found[c]),
            .winner_i (cls_win[c]),
            .rearm_i  (wr_ctrl && bus_wdata_i[c]),
            .req_o    (cls_req[c]),
            .code_o   (cls_code[c])
        );
    end

    assign irq_o = cls_req[CLS_NORM];
    assign fiq_o = cls_req[CLS_FAST];

    // ---------------- pending register ----------------
    logic [LINES-1:0] keep_w;
    logic [LINES-1:0] ack_clr_w;
    logic [LINES-1:0] trig_hot_w;
    logic [LINES-1:0] trig_set_w;
    logic [LINES-1:0] set_w;
    logic [LINES-1:0] pend_d;

    always_comb begin
        keep_w = wr_pend ? (bus_wdata_i[LINES-1:0] | (sync_w & lvl_q)) : '1;
        ack_clr_w = '0;
        if (rd_code_n && !lvl_q[cls_code[CLS_NORM]]) ack_clr_w[cls_code[CLS_NORM]] = 1'b1;
        if (rd_code_f && !lvl_q[cls_code[CLS_FAST]]) ack_clr_w[cls_code[CLS_FAST]] = 1'b1;
        trig_hot_w = wr_trig ? (bus_wdata_i[LINES-1:0] & (~bus_wdata_i[LINES-1:0] + 1'b1)) : '0;
        trig_set_w = trig_hot_w & (lvl_q | ~sync_w);
        set_w      = (rise_w & ~lvl_q) | (sync_w & lvl_q) | trig_set_w;
        pend_d     = (pend_q & keep_w & ~ack_clr_w & ~(fall_w & lvl_q)) | set_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    // ---------------- read path ----------------
    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        rd_d = '0;
        if (bus_addr_i == ADDR_W'(A_PEND))        rd_d = DATA_W'(pend_q);
        else if (bus_addr_i == ADDR_W'(A_MASK))   rd_d = DATA_W'(mask_q);
        else if (bus_addr_i == ADDR_W'(A_CODE_N)) rd_d = DATA_W'(cls_code[CLS_NORM]);
        else if (bus_addr_i == ADDR_W'(A_CODE_F)) rd_d = DATA_W'(cls_code[CLS_FAST]);
        else if (cfg_hit)
            rd_d = DATA_W'({prio_q[cfg_idx*PRIO_W +: PRIO_W], lvl_q[cfg_idx], steer_q[cfg_idx]});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    rdata_q <= '0;
        else if (rd_go) rdata_q <= rd_d;
    end

    assign bus_rdata_o = rdata_q;

    // ---------------- assertions ----------------
    for (genvar i = 0; i < int'(LINES); i++) begin : g_chk
        a_r4_level_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lvl_q[i] && sync_w[i]) |=> pend_q[i]);

        a_r3_edge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pend_q[i] && !lvl_q[i] && !bus_wr_i && !bus_rd_i) |=> pend_q[i]);
    end

    a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_code_n && !lvl_q[cls_code[CLS_NORM]] && !set_w[cls_code[CLS_NORM]])
        |=> !pend_q[$past(cls_code[CLS_NORM])]);

    a_r9_single_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(trig_set_w));

endmodule

// File: tb/sim_intc_bank.sv
module sim_intc_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [4:0]  pri [32];
    logic [31:0] steer_m;

    always #5 clk = ~clk;

    intc_bank u0 (
        .clk_i(clk), .rst_ni(rst_n), .lines_i(lines),
        .bus_wr_i(wr_en), .bus_rd_i(rd_en), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] cfg_a(input int n);
        return 8'(8'h1C + 4 * n);
    endfunction

    // returns {found, line}
    function automatic logic [5:0] model_win(input logic [31:0] act);
        logic [4:0] best = 5'h1F;
        logic [5:0] r = '0;
        for (int i = 0; i < 32; i++)
            if (act[i] && pri[i] <= best) begin
                best = pri[i];
                r = {1'b1, 5'(i)};
            end
        return r;
    endfunction

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] pend_m, pat, m;
        logic [5:0]  wn, wf;
        void'($urandom(32'd2024));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 fiq", 32'(fiq), 32'h0);
        rd(8'h00, d); chk("R1 pending", d, 32'h0);
        rd(8'h04, d); chk("R1 mask", d, 32'hFFFFFFFF);
        rd(cfg_a(5), d); chk("R1 cfg", d, 32'h0);
        // R11 control and trigger read zero
        rd(8'h18, d); chk("R11 control", d, 32'h0);
        rd(8'h9C, d); chk("R11 trigger", d, 32'h0);

        // R2 config layout
        wr(cfg_a(7), 32'h27);
        rd(cfg_a(7), d); chk("R2 cfg7", d, 32'h27);
        wr(cfg_a(3), 32'hFFFFFFFF);
        rd(cfg_a(3), d); chk("R2 cfg3 width", d, 32'h7F);
        wr(cfg_a(7), 0); wr(cfg_a(3), 0);

        // R3 edge line 2
        lines[2] = 1'b1; idle(4);
        rd(8'h00, d); chk("R3 edge set", d, 32'h4);
        lines[2] = 1'b0; idle(4);
        rd(8'h00, d); chk("R3 edge held", d, 32'h4);
        wr(8'h00, 32'h0);
        rd(8'h00, d); chk("R5 edge cleared", d, 32'h0);

        // R4 / R5 level line 4
        wr(cfg_a(4), 32'h2);
        lines[4] = 1'b1; idle(4);
        rd(8'h00, d); chk("R4 level set", d, 32'h10);
        wr(8'h00, 32'h0);
        rd(8'h00, d); chk("R5 level kept", d, 32'h10);
        lines[4] = 1'b0; idle(4);
        rd(8'h00, d); chk("R4 level cleared", d, 32'h0);

        // R9 trigger: lowest bit only; edge line with high input ignored
        wr(8'h9C, 32'h000000C0);
        rd(8'h00, d); chk("R9 lowest bit", d, 32'h40);
        lines[2] = 1'b1; idle(4);
        wr(8'h00, 32'h40);
        wr(8'h9C, 32'h4);
        rd(8'h00, d); chk("R9 edge high ignored", d, 32'h40);
        lines[2] = 1'b0; idle(4);

        // R6/R7/R8 capture, ack and rearm
        wr(8'h04, ~32'h40);
        idle(1);
        chk("R6 irq up", 32'(irq), 32'h1);
        chk("R6 fiq low", 32'(fiq), 32'h0);
        rd(8'h10, d); chk("R7 code", d, 32'd6);
        rd(8'h00, d); chk("R7 ack clear", d, 32'h0);
        wr(8'h9C, 32'h40); idle(2);
        chk("R8 held", 32'(irq), 32'h1);
        wr(8'h18, 32'h1);
        chk("R8 drop", 32'(irq), 32'h0);
        idle(1);
        chk("R8 refire", 32'(irq), 32'h1);
        rd(8'h10, d); chk("R8 code", d, 32'd6);
        wr(8'h04, 32'hFFFFFFFF);

        // R10 same-cycle rise and clearing write on line 2
        wr(8'h00, 32'h0);
        lines[2] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h00, d); chk("R10 set wins", d, 32'h4);
        lines[2] = 1'b0; idle(3);
        wr(8'h00, 32'h0);

        // R6 fast class
        wr(cfg_a(9), 32'hD);
        wr(8'h9C, 32'h200);
        wr(8'h04, ~32'h200);
        idle(1);
        chk("R6 fiq up", 32'(fiq), 32'h1);
        rd(8'h14, d); chk("R7 fast code", d, 32'd9);

        // random rounds
        for (int it = 0; it < 40; it++) begin
            steer_m = '0;
            for (int n = 0; n < 32; n++) begin
                pri[n] = 5'($urandom % 4);
                steer_m[n] = 1'($urandom % 2);
                wr(cfg_a(n), {25'b0, pri[n], 1'b0, steer_m[n]});
            end
            wr(8'h00, 32'h0);
            wr(8'h04, 32'hFFFFFFFF);
            wr(8'h18, 32'h3);
            pat = $urandom;
            for (int n = 0; n < 32; n++)
                if (pat[n]) wr(8'h9C, pat & (32'hFFFFFFFF << n));
            pend_m = pat;
            m = $urandom;
            wr(8'h04, m);
            idle(2);
            wn = model_win(pend_m & ~m & ~steer_m);
            wf = model_win(pend_m & ~m & steer_m);
            chk("R6 rand irq", 32'(irq), 32'(wn[5]));
            chk("R6 rand fiq", 32'(fiq), 32'(wf[5]));
            if (wn[5]) begin
                rd(8'h10, d); chk("R7 rand code", d, 32'(wn[4:0]));
                pend_m[wn[4:0]] = 1'b0;
            end
            if (wf[5]) begin
                rd(8'h14, d); chk("R7 rand fast code", d, 32'(wf[4:0]));
                pend_m[wf[4:0]] = 1'b0;
            end
            rd(8'h00, d); chk("R9 rand pending", d, pend_m);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule